// File: doc/BRIEF.md
# Block-Cipher Start Scheduler

This control unit decides when a block-cipher operation may start on a 128-bit text register and its companion buffer register, and which operand feeds that operation. A start can come from a manual operation code. It can also come indirectly from bus reads or writes of the last word of the text group. A third path is a write to the last word of the buffer group, which is held in a queue until the engine is free. The unit emits a one-cycle start pulse with a source select, keeps a busy flag for the modelled cipher latency, and ends each operation with a one-cycle done pulse.

Two other inputs shape when starts may happen. Completion events of DMA channel A can block the indirect paths, either at once or only after the channel's final buffer block has been consumed. An abort input ends any running operation and empties the queue. It also wipes the automatic-trigger settings and sends a one-cycle clear pulse to the neighbouring register, DMA and configuration storage. The cipher core is not part of the block. It is stood in for by a busy window of `LAT` cycles for the text source, and one cycle longer for the buffer and mixed sources.

Top module: `aes_trig_sched`

## Requirements
- R1: With the engine idle, a manual request (`man_wr`) carrying code 1 (text), 2 (buffer) or 3 (text XOR buffer) starts an operation. `start` is high for one cycle after the sampling edge, `start_src` equals the code, and `busy` rises together with `start`.
- R2: A manual request carrying code 0 is ignored, and so is any manual request made while `busy` is high. Neither one produces a `start`, then or later.
- R3: In `cfg_trig`, bit 0 makes a `txt3_wr` start an operation with source `cfg_src`, and bit 1 does the same for a `txt3_rd`. Both act only while idle and only when `cfg_src` is nonzero. Such events are dropped while busy.
- R4: With `cfg_trig` bit 2 set and `ctr_en` low, every `buf3_wr` queues a start. The queued start fires with source `cfg_src` in the same edge if the engine is idle, or in the cycle after `done` otherwise. With `ctr_en` high this path does nothing.
- R5: With `cfg_trig` bit 3 set, only the first `buf3_wr` queues a start. Further writes do nothing until a new configuration write with bit 3 set re-arms the path.
- R6: `buf_full` is 1 while a start queued under bit 2 is not yet consumed, and falls on the edge where that start fires. It stays 0 when bit 2 is clear, including while a bit-3 start waits.
- R7: `busy` stays high for `LAT` cycles with the text source and `LAT`+1 cycles with sources 2 and 3. `done` pulses for one cycle in the first cycle after `busy` falls. Out of reset, all outputs are 0.
- R8: With `done_act` bit 0 set, indirect and queued starts are blocked while `cha_done` is high. A queued start is held, not lost.
- R9: With `done_act` bit 1 set, blocking begins only after an operation starts that follows a `cha_last_wr` pulse, and only while `cha_done` is high. It is lifted when `cha_done` falls.
- R10: If a valid manual request and an indirect event arrive in the same idle cycle, the manual code wins and the immediate indirect event is dropped. A queued buffer start survives and fires after that operation.
- R11: `abort` drops `busy` in the next cycle without a `done` pulse. It empties the queue, zeroes the trigger configuration and source, and pulses `clr_regs` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| man_wr | input | 1 | Manual operation request strobe |
| man_op | input | 2 | Manual operation code (1 text, 2 buffer, 3 text XOR buffer) |
| cfg_wr | input | 1 | Write strobe for the automatic trigger settings |
| cfg_trig | input | 4 | Indirect trigger mask (bit0 txt write, bit1 txt read, bit2 buffer queue, bit3 buffer single) |
| cfg_src | input | 2 | Operand source for indirect and queued starts |
| ctr_en | input | 1 | Counter mode active (disables the bit-2 queue) |
| done_act | input | 2 | DMA-done gating (bit0 immediate, bit1 delayed; not both) |
| cha_done | input | 1 | Channel A done flag |
| cha_last_wr | input | 1 | Pulse on the final channel A buffer write |
| txt3_wr | input | 1 | Bus write of text word 3 or its XOR alias |
| txt3_rd | input | 1 | Bus read of text word 3 or the text-XOR-buffer word 3 |
| buf3_wr | input | 1 | Bus write of buffer word 3 |
| abort | input | 1 | Abort request |
| start | output | 1 | One-cycle operation start pulse |
| start_src | output | 2 | Operand source of the latest start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| buf_full | output | 1 | Queued buffer block not yet consumed |
| clr_regs | output | 1 | One-cycle clear pulse issued after an abort |

## Verification
A request sampled at an edge shows up on `start`, `start_src`, `busy`, `buf_full` and `clr_regs` right after that same edge. `done` arrives `LAT` edges after the start edge for the text source and `LAT`+1 for the others, and a queued start fires one edge after `done`. Inputs are driven on falling clock edges and every output is read on the next falling edge. Latency checks step exactly the computed number of edges and then sample `busy` and `done` there. The only exceptions are the waits for a queued start, which loop until `done` is seen and then take one further step before checking.

// File: rtl/aes_trig_pkg.sv
package aes_trig_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TXT  = 2'd1,
        SRC_BUF  = 2'd2,
        SRC_MIX  = 2'd3
    } src_e;

    localparam int TRG_W      = 4;
    localparam int TRG_TXT_WR = 0;
    localparam int TRG_TXT_RD = 1;
    localparam int TRG_BUF_Q  = 2;
    localparam int TRG_BUF_1  = 3;

    localparam int GATE_NOW = 0;
    localparam int GATE_DLY = 1;

    typedef struct packed {
        logic fire;
        src_e src;
    } launch_t;

    function automatic int op_cycles(src_e s, int base);
        return (s == SRC_TXT) ? base : base + 1;
    endfunction

endpackage

// File: rtl/aes_trig_queue.sv
module aes_trig_queue
    import aes_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             cfg_wr,
    input  logic [TRG_W-1:0] cfg_trig,
    input  logic [1:0]       cfg_src,
    input  logic             ctr_en,
    input  logic             buf3_wr,
    input  logic             q_take,
    output logic [TRG_W-1:0] trig_q,
    output src_e             src_q,
    output logic             pend_eff,
    output logic             buf_full
);
    logic armed_q;
    logic pend_q;
    logic multi_ok;
    logic single_ok;
    logic q_new;

    assign multi_ok  = trig_q[TRG_BUF_Q] & ~ctr_en;
    assign single_ok = trig_q[TRG_BUF_1] & armed_q;
    assign q_new     = buf3_wr & (multi_ok | single_ok);
    assign pend_eff  = pend_q | q_new;
    assign buf_full  = trig_q[TRG_BUF_Q] & pend_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            trig_q  <= '0;
            src_q   <= SRC_NONE;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (cfg_wr) begin
                trig_q  <= cfg_trig;
                src_q   <= src_e'(cfg_src);
                armed_q <= cfg_trig[TRG_BUF_1];
            end else if (buf3_wr && single_ok) begin
                armed_q <= 1'b0;
            end
            pend_q <= pend_eff & ~q_take;
        end
    end

endmodule

// File: rtl/aes_trig_gate.sv
module aes_trig_gate
    import aes_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       abort,
    input  logic [1:0] done_act,
    input  logic       cha_done,
    input  logic       cha_last_wr,
    input  logic       fire,
    output logic       gate
);
    logic last_seen_q;
    logic dly_on_q;
    logic cha_done_q;

    assign gate = (done_act[GATE_NOW] & cha_done)
                | (done_act[GATE_DLY] & dly_on_q & cha_done);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            last_seen_q <= 1'b0;
            dly_on_q    <= 1'b0;
            cha_done_q  <= 1'b0;
        end else begin
            cha_done_q <= cha_done;
            if (cha_last_wr)
                last_seen_q <= 1'b1;
            else if (fire)
                last_seen_q <= 1'b0;
            if (fire && (last_seen_q || cha_last_wr))
                dly_on_q <= 1'b1;
            else if (cha_done_q && !cha_done)
                dly_on_q <= 1'b0;
        end
    end

endmodule

// File: rtl/aes_trig_arb.sv
module aes_trig_arb
    import aes_trig_pkg::*;
(
    input  logic             idle,
    input  logic             gate,
    input  logic             man_wr,
    input  logic [1:0]       man_op,
    input  logic [TRG_W-1:0] trig_q,
    input  src_e             src_q,
    input  logic             txt3_wr,
    input  logic             txt3_rd,
    input  logic             pend_eff,
    output launch_t          launch,
    output logic             q_take
);
    logic man_ok;
    logic ind_ok;
    logic imm_hit;
    logic que_hit;

    assign man_ok  = idle & man_wr & (man_op != 2'd0);
    assign ind_ok  = idle & ~gate & (src_q != SRC_NONE);
    assign imm_hit = ind_ok & ((trig_q[TRG_TXT_WR] & txt3_wr)
                             | (trig_q[TRG_TXT_RD] & txt3_rd));
    assign que_hit = ind_ok & pend_eff;

    always_comb begin
        launch.fire = 1'b0;
        launch.src  = SRC_NONE;
        q_take      = 1'b0;
        if (man_ok) begin
            launch.fire = 1'b1;
            launch.src  = src_e'(man_op);
        end else if (imm_hit || que_hit) begin
            launch.fire = 1'b1;
            launch.src  = src_q;
            q_take      = que_hit;
        end
    end

endmodule

// File: rtl/aes_trig_engine.sv
module aes_trig_engine
    import aes_trig_pkg::*;
#(
    parameter int LAT = 12
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    abort,
    input  launch_t launch,
    output logic    start,
    output src_e    start_src,
    output logic    busy,
    output logic    done
);
    localparam int CW = $clog2(LAT + 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            start     <= 1'b0;
            start_src <= SRC_NONE;
            busy      <= 1'b0;
            done      <= 1'b0;
            cnt_q     <= '0;
        end else begin
            start <= launch.fire;
            done  <= 1'b0;
            if (launch.fire) begin
                busy      <= 1'b1;
                start_src <= launch.src;
                cnt_q     <= CW'(op_cycles(launch.src, LAT) - 1);
            end else if (busy) begin
                if (cnt_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    p_start_idle_r1: assert property (@(posedge clk) disable iff (rst)
        start |-> (busy && !$past(busy)));
    p_start_src_r1: assert property (@(posedge clk) disable iff (rst)
        start |-> (start_src != SRC_NONE));
    p_done_end_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    p_done_once_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/aes_trig_sched.sv
module aes_trig_sched
    import aes_trig_pkg::*;
#(
    parameter int LAT = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       man_wr,
    input  logic [1:0] man_op,
    input  logic       cfg_wr,
    input  logic [3:0] cfg_trig,
    input  logic [1:0] cfg_src,
    input  logic       ctr_en,
    input  logic [1:0] done_act,
    input  logic       cha_done,
    input  logic       cha_last_wr,
    input  logic       txt3_wr,
    input  logic       txt3_rd,
    input  logic       buf3_wr,
    input  logic       abort,
    output logic       start,
    output logic [1:0] start_src,
    output logic       busy,
    output logic       done,
    output logic       buf_full,
    output logic       clr_regs
);
    logic [TRG_W-1:0] trig_q;
    src_e             src_q;
    src_e             src_o;
    logic             pend_eff;
    logic             q_take;
    logic             gate;
    launch_t          launch;

    aes_trig_queue u_queue (
        .clk(clk), .rst(rst), .abort(abort),
        .cfg_wr(cfg_wr), .cfg_trig(cfg_trig), .cfg_src(cfg_src),
        .ctr_en(ctr_en), .buf3_wr(buf3_wr), .q_take(q_take),
        .trig_q(trig_q), .src_q(src_q), .pend_eff(pend_eff),
        .buf_full(buf_full)
    );

    aes_trig_gate u_gate (
        .clk(clk), .rst(rst), .abort(abort),
        .done_act(done_act), .cha_done(cha_done),
        .cha_last_wr(cha_last_wr), .fire(launch.fire), .gate(gate)
    );

    aes_trig_arb u_arb (
        .idle(~busy), .gate(gate), .man_wr(man_wr), .man_op(man_op),
        .trig_q(trig_q), .src_q(src_q), .txt3_wr(txt3_wr),
        .txt3_rd(txt3_rd), .pend_eff(pend_eff),
        .launch(launch), .q_take(q_take)
    );

    aes_trig_engine #(.LAT(LAT)) u_eng (
        .clk(clk), .rst(rst), .abort(abort), .launch(launch),
        .start(start), .start_src(src_o), .busy(busy), .done(done)
    );

    assign start_src = src_o;

    always_ff @(posedge clk) begin
        if (rst) clr_regs <= 1'b0;
        else     clr_regs <= abort;
    end

    p_abort_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        $past(abort) |-> (!busy && !start && !done && !buf_full && clr_regs));
    p_full_consumed_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(buf_full) && !$past(abort) && !$past(cfg_wr)) |-> start);
    p_gate_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(done_act[GATE_NOW]) && $past(cha_done) && !$past(man_wr)) |-> !start);

endmodule

// File: tb/sim_aes_trig_sched.sv
module sim_aes_trig_sched;

    localparam int LAT = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       man_wr = 0, cfg_wr = 0, ctr_en = 0, cha_done = 0, cha_last_wr = 0;
    logic       txt3_wr = 0, txt3_rd = 0, buf3_wr = 0, abort = 0;
    logic [1:0] man_op = 0, cfg_src = 0, done_act = 0;
    logic [3:0] cfg_trig = 0;
    logic       start, busy, done, buf_full, clr_regs;
    logic [1:0] start_src;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    aes_trig_sched #(.LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .man_wr(man_wr), .man_op(man_op),
        .cfg_wr(cfg_wr), .cfg_trig(cfg_trig), .cfg_src(cfg_src),
        .ctr_en(ctr_en), .done_act(done_act), .cha_done(cha_done),
        .cha_last_wr(cha_last_wr), .txt3_wr(txt3_wr), .txt3_rd(txt3_rd),
        .buf3_wr(buf3_wr), .abort(abort), .start(start),
        .start_src(start_src), .busy(busy), .done(done),
        .buf_full(buf_full), .clr_regs(clr_regs)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, 50000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        man_wr = 0; cfg_wr = 0; txt3_wr = 0; txt3_rd = 0;
        buf3_wr = 0; abort = 0; cha_last_wr = 0;
    endtask

    task automatic set_cfg(input logic [3:0] t, input logic [1:0] s);
        cfg_trig = t; cfg_src = s; cfg_wr = 1;
        step();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) step();
        step();
    endtask

    task automatic wait_done();
        for (int i = 0; i < 100 && !done; i++) step();
    endtask

    task automatic manual(input logic [1:0] op);
        man_op = op; man_wr = 1;
        step();
    endtask

    task automatic t_reset();
        chk(start, 0, "R7 reset start");
        chk(busy, 0, "R7 reset busy");
        chk(done, 0, "R7 reset done");
        chk(buf_full, 0, "R6 reset buf_full");
        chk(clr_regs, 0, "R11 reset clr_regs");
    endtask

    task automatic t_manual(input logic [1:0] op, input int len);
        manual(op);
        chk(start, 1, "R1 start");
        chk(start_src, op, "R1 src");
        chk(busy, 1, "R1 busy");
        repeat (len - 1) step();
        chk(busy, 1, "R7 busy late");
        chk(done, 0, "R7 no early done");
        step();
        chk(busy, 0, "R7 busy fall");
        chk(done, 1, "R7 done pulse");
        step();
        chk(done, 0, "R7 done single");
    endtask

    task automatic t_ignored();
        manual(2'd0);
        chk(start, 0, "R2 code0");
        chk(busy, 0, "R2 code0 busy");
        manual(2'd1);
        step();
        manual(2'd2);
        chk(start, 0, "R2 busy request");
        wait_idle();
        chk(start, 0, "R2 no late start");
        chk(busy, 0, "R2 idle");
    endtask

    task automatic t_txt();
        set_cfg(4'b0001, 2'd1);
        txt3_rd = 1; step();
        chk(start, 0, "R3 read without bit1");
        txt3_wr = 1; step();
        chk(start, 1, "R3 write start");
        chk(start_src, 1, "R3 write src");
        step();
        txt3_wr = 1; step();
        chk(start, 0, "R3 busy drop");
        wait_idle();
        chk(start, 0, "R3 busy drop late");
        set_cfg(4'b0010, 2'd3);
        txt3_rd = 1; step();
        chk(start, 1, "R3 read start");
        chk(start_src, 3, "R3 read src");
        wait_idle();
        set_cfg(4'b0011, 2'd0);
        txt3_wr = 1; step();
        chk(start, 0, "R3 src zero");
    endtask

    task automatic t_queue();
        set_cfg(4'b0100, 2'd2);
        buf3_wr = 1; step();
        chk(start, 1, "R4 idle immediate");
        chk(buf_full, 0, "R6 consumed at once");
        wait_idle();
        manual(2'd1);
        buf3_wr = 1; step();
        chk(start, 0, "R4 held while busy");
        chk(buf_full, 1, "R6 full while queued");
        wait_done();
        chk(buf_full, 1, "R6 full at done");
        step();
        chk(start, 1, "R4 fires after done");
        chk(start_src, 2, "R4 src");
        chk(buf_full, 0, "R6 empty after fire");
        wait_idle();
        ctr_en = 1;
        buf3_wr = 1; step();
        chk(start, 0, "R4 counter mode");
        chk(buf_full, 0, "R4 counter no queue");
        step();
        chk(start, 0, "R4 counter later");
        ctr_en = 0;
    endtask

    task automatic t_single();
        set_cfg(4'b1000, 2'd2);
        buf3_wr = 1; step();
        chk(start, 1, "R5 first write");
        wait_idle();
        buf3_wr = 1; step();
        chk(start, 0, "R5 second write");
        step();
        chk(start, 0, "R5 second write late");
        set_cfg(4'b1000, 2'd2);
        manual(2'd1);
        buf3_wr = 1; step();
        chk(buf_full, 0, "R6 flag off in bit3 mode");
        wait_done();
        step();
        chk(start, 1, "R5 rearmed fires");
        chk(start_src, 2, "R5 rearmed src");
        wait_idle();
    endtask

    task automatic t_gate();
        set_cfg(4'b0001, 2'd1);
        done_act = 2'b01; cha_done = 1;
        txt3_wr = 1; step();
        chk(start, 0, "R8 gated");
        cha_done = 0;
        txt3_wr = 1; step();
        chk(start, 1, "R8 released");
        wait_idle();
        set_cfg(4'b0100, 2'd2);
        cha_done = 1;
        buf3_wr = 1; step();
        chk(start, 0, "R8 queue gated");
        chk(buf_full, 1, "R8 queue held");
        cha_done = 0; step();
        chk(start, 1, "R8 queue fires");
        wait_idle();
        done_act = 2'b00;
    endtask

    task automatic t_gate_dly();
        set_cfg(4'b0001, 2'd1);
        done_act = 2'b10; cha_done = 1;
        txt3_wr = 1; step();
        chk(start, 1, "R9 not yet gated");
        cha_last_wr = 1; step();
        wait_idle();
        txt3_wr = 1; step();
        chk(start, 1, "R9 consuming start");
        wait_idle();
        txt3_wr = 1; step();
        chk(start, 0, "R9 gated after consume");
        cha_done = 0; step();
        cha_done = 1; step();
        txt3_wr = 1; step();
        chk(start, 1, "R9 lifted by fall");
        wait_idle();
        done_act = 2'b00; cha_done = 0;
    endtask

    task automatic t_prio();
        set_cfg(4'b0001, 2'd2);
        man_op = 2'd1; man_wr = 1; txt3_wr = 1; step();
        chk(start, 1, "R10 start");
        chk(start_src, 1, "R10 manual wins");
        wait_idle();
        chk(start, 0, "R10 indirect dropped");
        set_cfg(4'b0100, 2'd2);
        man_op = 2'd1; man_wr = 1; buf3_wr = 1; step();
        chk(start_src, 1, "R10 manual src");
        chk(buf_full, 1, "R10 queue kept");
        wait_done();
        step();
        chk(start, 1, "R10 queued fires");
        chk(start_src, 2, "R10 queued src");
        wait_idle();
    endtask

    task automatic t_abort();
        int seen;
        set_cfg(4'b0101, 2'd2);
        manual(2'd3);
        step(); step();
        buf3_wr = 1; step();
        chk(buf_full, 1, "R11 queued before abort");
        abort = 1; step();
        chk(busy, 0, "R11 busy cleared");
        chk(clr_regs, 1, "R11 clear pulse");
        chk(buf_full, 0, "R11 queue emptied");
        step();
        chk(clr_regs, 0, "R11 clear single");
        seen = 0;
        for (int i = 0; i < LAT + 4; i++) begin
            if (done || start) seen++;
            step();
        end
        chk(seen, 0, "R11 no done or start");
        txt3_wr = 1; step();
        chk(start, 0, "R11 config cleared");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        step();
        t_reset();
        t_manual(2'd1, LAT);
        t_manual(2'd2, LAT + 1);
        t_manual(2'd3, LAT + 1);
        t_ignored();
        t_txt();
        t_queue();
        t_single();
        t_gate();
        t_gate_dly();
        t_prio();
        t_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule